// File: doc/BRIEF.md
# Multi-Cycle Multiply-Accumulate Unit

This block is the multiply engine beside a scalar integer pipeline. Each issued operation brings two 32-bit source operands, a 3-bit operation code and a 4-bit destination register tag. Products go back to a register-file write port as a one-cycle `result_valid` pulse that carries the tag. The unit also holds a private 40-bit accumulator. Accumulating operations add into it, one operation loads it from two general registers, and another reads its low word back out.

The unit is not fully pipelined. An operation is accepted on a rising edge where `issue_valid` and `issue_ready` are both high. It then spends the next cycle in stage M1 and advances one stage per cycle. It retires in M2, M3, M4 or M5, and which one depends on the opcode and the size of the operands. At most two operations are held at once. A second one is admitted only when the current occupant will retire in the following cycle, so short 16-bit operations still flow at one per cycle.

The main pipeline can raise `flush`. An operation still in M1 or M2 is then dropped without effect. An operation in M3 to M5 has passed the point of no return and completes anyway. Opcodes: 0 = 16x16, 1 = 32x16, 2 = 32x32 low word, 3 = 32x32 high word, 4 = accumulate product, 5 = accumulate dual 16-bit products, 6 = load accumulator, 7 = read accumulator.

Top module: `mac_unit`

## Requirements
- R1: After reset, `issue_ready` is high and `result_valid` is low.
- R2: Opcode 0 returns the 32-bit signed product of `a[15:0]` and `b[15:0]`. Opcode 1 returns the low 32 bits of signed `a` times signed `b[15:0]`. Both retire in M2, which is the second cycle after acceptance.
- R3: Opcode 2 returns the low 32 bits of the signed 64-bit product of `a` and `b`. It retires in M3 when `b[31:16]` all equal `b[15]`, and in M4 otherwise.
- R4: Opcode 3 returns bits 63:32 of the signed 64-bit product of `a` and `b`, and retires in M5.
- R5: Opcode 4 adds signed `a*b` to the accumulator. Opcode 5 adds the signed sum `a[15:0]*b[15:0] + a[31:16]*b[31:16]`. Both wrap modulo 2^40, retire in M5 and raise no `result_valid`.
- R6: Opcode 6 sets the accumulator to `{a[7:0], b}` in M2 without raising `result_valid`. Opcode 7 returns the low 32 accumulator bits in M2, and that value includes every accumulator operation issued before it.
- R7: `issue_ready` is low while `flush` is high. Otherwise it is high exactly when, after the current cycle, either no operation remains or the single remaining one retires in the next cycle. Back-to-back 16-bit operations are accepted every cycle.
- R8: A flush while an operation is in M1 or M2 cancels it. It produces no result and leaves the accumulator unchanged.
- R9: An operation in M3, M4 or M5 completes normally even when `flush` is high.
- R10: `result_tag` equals the tag that was presented with the operation at issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is offered |
| issue_ready | output | 1 | The unit will accept the offered operation on this edge |
| issue_op | input | 3 | Operation code |
| issue_a | input | 32 | First source operand |
| issue_b | input | 32 | Second source operand |
| issue_tag | input | 4 | Destination register tag |
| flush | input | 1 | Cancel operations still in M1 or M2 |
| result_valid | output | 1 | One-cycle pulse: register result available |
| result_tag | output | 4 | Destination tag of the result |
| result_data | output | 32 | Result word |

## Verification
On every cycle the assertions check the admission rules: issue is blocked during a flush, and a long operation holds off the next issue in its M1 cycle. They also check the fixed M2 retire time and tag of short operations, that a flush in M1 suppresses that result, and that a high-word multiply past M2 always delivers at M5. Arithmetic correctness of every opcode is shown only by the bench's operand sweeps over signed corner values. So are the operand-size-dependent latency of the 32x32 low-word multiply, accumulator ordering and wrap, and the absence of accumulator change after a cancelled accumulate or load.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DATA_W   = 32;
    localparam int ACC_W    = 40;
    localparam int TAG_W    = 4;
    localparam int OP_W     = 3;
    localparam int STAGE_W  = 3;
    localparam int NUM_SLOTS = 2;

    localparam int HALF_W   = DATA_W / 2;
    localparam int PROD_W   = 2 * DATA_W;
    localparam int ACC_HI_W = ACC_W - DATA_W;

    localparam logic [STAGE_W-1:0] ST_M1 = STAGE_W'(1);
    localparam logic [STAGE_W-1:0] ST_M2 = STAGE_W'(2);
    localparam logic [STAGE_W-1:0] ST_M3 = STAGE_W'(3);
    localparam logic [STAGE_W-1:0] ST_M4 = STAGE_W'(4);
    localparam logic [STAGE_W-1:0] ST_M5 = STAGE_W'(5);

    typedef enum logic [OP_W-1:0] {
        OP_M16   = 3'd0,
        OP_M16W  = 3'd1,
        OP_M32   = 3'd2,
        OP_M32H  = 3'd3,
        OP_MACC  = 3'd4,
        OP_MACC2 = 3'd5,
        OP_ACCLD = 3'd6,
        OP_ACCRD = 3'd7
    } mac_op_e;

    typedef struct packed {
        logic                vld;
        logic [STAGE_W-1:0]  stage;
        logic [STAGE_W-1:0]  fin;
        mac_op_e             op;
        logic [TAG_W-1:0]    tag;
        logic [PROD_W-1:0]   prod;
    } slot_t;

    function automatic logic writes_reg(input mac_op_e op);
        return op inside {OP_M16, OP_M16W, OP_M32, OP_M32H, OP_ACCRD};
    endfunction

    function automatic logic updates_acc(input mac_op_e op);
        return op inside {OP_MACC, OP_MACC2, OP_ACCLD};
    endfunction

    function automatic logic b_is_narrow(input logic [DATA_W-1:0] b);
        return b[DATA_W-1:HALF_W] == {HALF_W{b[HALF_W-1]}};
    endfunction

    function automatic logic [STAGE_W-1:0] retire_stage(input mac_op_e op,
                                                        input logic [DATA_W-1:0] b);
        case (op)
            OP_M16, OP_M16W, OP_ACCLD, OP_ACCRD: return ST_M2;
            OP_M32:  return b_is_narrow(b) ? ST_M3 : ST_M4;
            default: return ST_M5;
        endcase
    endfunction

endpackage

// File: rtl/mac_operand.sv
module mac_operand
    import mac_pkg::*;
(
    input  mac_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [PROD_W-1:0]   prod,
    output logic [STAGE_W-1:0]  fin
);
    logic [PROD_W-1:0] a_ext, b_ext;
    logic [PROD_W-1:0] alo_ext, ahi_ext, blo_ext, bhi_ext;
    logic [PROD_W-1:0] p_ww, p_wh, p_hh, p_dual;

    assign a_ext   = {{DATA_W{a[DATA_W-1]}}, a};
    assign b_ext   = {{DATA_W{b[DATA_W-1]}}, b};
    assign alo_ext = {{(PROD_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
    assign ahi_ext = {{(PROD_W-HALF_W){a[DATA_W-1]}}, a[DATA_W-1:HALF_W]};
    assign blo_ext = {{(PROD_W-HALF_W){b[HALF_W-1]}}, b[HALF_W-1:0]};
    assign bhi_ext = {{(PROD_W-HALF_W){b[DATA_W-1]}}, b[DATA_W-1:HALF_W]};

    // Sign-extended operands make the modulo-2^64 product the exact signed product.
    assign p_ww   = a_ext * b_ext;
    assign p_wh   = a_ext * blo_ext;
    assign p_hh   = alo_ext * blo_ext;
    assign p_dual = (alo_ext * blo_ext) + (ahi_ext * bhi_ext);

    always_comb begin
        prod = '0;
        case (op)
            OP_M16:   prod = p_hh;
            OP_M16W:  prod = p_wh;
            OP_MACC2: prod = p_dual;
            OP_ACCLD: prod[ACC_W-1:0] = {a[ACC_HI_W-1:0], b};
            OP_ACCRD: prod = '0;
            default:  prod = p_ww;
        endcase
    end

    assign fin = retire_stage(op, b);

endmodule

// File: rtl/mac_slot.sv
module mac_slot
    import mac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  load,
    input  slot_t load_val,
    output slot_t cur,
    output logic  fire,
    output logic  leave,
    output logic  near
);
    logic at_end;
    logic cancel;

    assign at_end = cur.vld && (cur.stage == cur.fin);
    assign cancel = cur.vld && flush && (cur.stage <= ST_M2);
    assign leave  = at_end || cancel;
    assign fire   = at_end && !cancel;
    assign near   = cur.vld && ((cur.stage + STAGE_W'(1)) == cur.fin);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (leave) begin
            cur.vld <= 1'b0;
        end else if (cur.vld) begin
            cur.stage <= cur.stage + STAGE_W'(1);
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               is_load,
    input  logic [ACC_W-1:0]   src,
    output logic [DATA_W-1:0]  rd_lo
);
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (wr_en) begin
            acc_q <= is_load ? src : (acc_q + src);
        end
    end

    assign rd_lo = acc_q[DATA_W-1:0];

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_valid,
    output logic               issue_ready,
    input  logic [OP_W-1:0]    issue_op,
    input  logic [DATA_W-1:0]  issue_a,
    input  logic [DATA_W-1:0]  issue_b,
    input  logic [TAG_W-1:0]   issue_tag,
    input  logic               flush,
    output logic               result_valid,
    output logic [TAG_W-1:0]   result_tag,
    output logic [DATA_W-1:0]  result_data
);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    mac_op_e             new_op;
    logic [PROD_W-1:0]   new_prod;
    logic [STAGE_W-1:0]  new_fin;
    slot_t               new_entry;
    logic                accept;

    assign new_op = mac_op_e'(issue_op);

    mac_operand u_operand (
        .op   (new_op),
        .a    (issue_a),
        .b    (issue_b),
        .prod (new_prod),
        .fin  (new_fin)
    );

    always_comb begin
        new_entry.vld   = 1'b1;
        new_entry.stage = ST_M1;
        new_entry.fin   = new_fin;
        new_entry.op    = new_op;
        new_entry.tag   = issue_tag;
        new_entry.prod  = new_prod;
    end

    slot_t               slot_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] fire, leave, near, load, stays;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            mac_slot u_slot (
                .clk      (clk),
                .rst      (rst),
                .flush    (flush),
                .load     (load[g]),
                .load_val (new_entry),
                .cur      (slot_q[g]),
                .fire     (fire[g]),
                .leave    (leave[g]),
                .near     (near[g])
            );
            assign stays[g] = slot_q[g].vld && !leave[g];
        end
    endgenerate

    // Admission: nothing left after this cycle, or the one left retires next cycle.
    logic [CNT_W-1:0] n_stay;
    assign n_stay      = CNT_W'($countones(stays));
    assign issue_ready = !flush &&
                         ((n_stay == '0) ||
                          ((n_stay == CNT_W'(1)) && (|(stays & near))));
    assign accept      = issue_valid && issue_ready;

    logic alloc_taken;
    always_comb begin
        alloc_taken = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            load[i] = accept && !stays[i] && !alloc_taken;
            if (!stays[i]) alloc_taken = 1'b1;
        end
    end

    // At most one slot retires in any cycle; pick it.
    logic               any_fire;
    mac_op_e            sel_op;
    logic [TAG_W-1:0]   sel_tag;
    logic [PROD_W-1:0]  sel_prod;

    always_comb begin
        any_fire = 1'b0;
        sel_op   = OP_M16;
        sel_tag  = '0;
        sel_prod = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (fire[i]) begin
                any_fire = 1'b1;
                sel_op   = slot_q[i].op;
                sel_tag  = slot_q[i].tag;
                sel_prod = slot_q[i].prod;
            end
        end
    end

    logic [DATA_W-1:0] acc_lo;

    mac_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (any_fire && updates_acc(sel_op)),
        .is_load (sel_op == OP_ACCLD),
        .src     (sel_prod[ACC_W-1:0]),
        .rd_lo   (acc_lo)
    );

    always_comb begin
        result_valid = any_fire && writes_reg(sel_op);
        result_tag   = sel_tag;
        case (sel_op)
            OP_ACCRD: result_data = acc_lo;
            OP_M32H:  result_data = sel_prod[PROD_W-1:DATA_W];
            default:  result_data = sel_prod[DATA_W-1:0];
        endcase
    end

endmodule

// File: rtl/mac_unit_checker.sv
module mac_unit_checker
    import mac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               issue_valid,
    input logic               issue_ready,
    input logic [OP_W-1:0]    issue_op,
    input logic [TAG_W-1:0]   issue_tag,
    input logic               flush,
    input logic               result_valid,
    input logic [TAG_W-1:0]   result_tag
);
    logic take, is_short, is_long, is_hi;
    assign take     = issue_valid && issue_ready;
    assign is_short = mac_op_e'(issue_op) inside {OP_M16, OP_M16W, OP_ACCRD};
    assign is_long  = mac_op_e'(issue_op) inside {OP_M32H, OP_MACC, OP_MACC2};
    assign is_hi    = mac_op_e'(issue_op) == OP_M32H;

    logic s1, s2, k2, h1, h2, h3, h4, h5;
    logic [TAG_W-1:0] s1_tag, s2_tag, h1_tag, h2_tag, h3_tag, h4_tag, h5_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            {s1, s2, k2, h1, h2, h3, h4, h5} <= '0;
            {s1_tag, s2_tag, h1_tag, h2_tag, h3_tag, h4_tag, h5_tag} <= '0;
        end else begin
            s1     <= take && is_short;
            s1_tag <= issue_tag;
            s2     <= s1 && !flush;
            s2_tag <= s1_tag;
            k2     <= s1 && flush;
            h1     <= take && is_hi;
            h1_tag <= issue_tag;
            h2     <= h1 && !flush;
            h2_tag <= h1_tag;
            h3     <= h2 && !flush;
            h3_tag <= h2_tag;
            h4     <= h3;
            h4_tag <= h3_tag;
            h5     <= h4;
            h5_tag <= h4_tag;
        end
    end

    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !flush) |-> issue_ready);

    a_r7_flush_blocks_issue: assert property (@(posedge clk) disable iff (rst)
        flush |-> !issue_ready);

    a_r7_long_holds_issue: assert property (@(posedge clk) disable iff (rst)
        (take && is_long) |=> !issue_ready);

    // R2 and R10: short operation retires in M2 with its own tag.
    a_r2_short_result: assert property (@(posedge clk) disable iff (rst)
        (s2 && !flush) |-> (result_valid && result_tag == s2_tag));

    a_r8_flush_cancels_short: assert property (@(posedge clk) disable iff (rst)
        k2 |-> !result_valid);

    a_r9_committed_hi_result: assert property (@(posedge clk) disable iff (rst)
        h5 |-> (result_valid && result_tag == h5_tag));

endmodule

bind mac_unit mac_unit_checker u_mac_chk (.*);

// File: tb/mac_unit_bench.sv
module mac_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [2:0]  issue_op = '0;
    logic [31:0] issue_a = '0;
    logic [31:0] issue_b = '0;
    logic [3:0]  issue_tag = '0;
    logic        flush = 1'b0;
    logic        result_valid;
    logic [3:0]  result_tag;
    logic [31:0] result_data;

    always #10 clk = ~clk;   // 50 MHz

    mac_unit u_mac_unit (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    int rv_seen = 0;
    logic [39:0] m_acc = '0;
    string rd_req = "R6";

    typedef struct {
        int          due;
        logic [3:0]  tag;
        logic [31:0] data;
        string       req;
    } exp_t;
    exp_t expq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_7FFF;
            4: return 32'hFFFF_8000;
            5: return 32'h7FFF_FFFF;
            6: return 32'h8000_0000;
            default: return 32'h0001_A5C3;
        endcase
    endfunction

    function automatic int fin_of(input logic [2:0] op, input logic [31:0] b);
        case (op)
            3'd0, 3'd1, 3'd6, 3'd7: return 2;
            3'd2: return (b[31:16] == {16{b[15]}}) ? 3 : 4;
            default: return 5;
        endcase
    endfunction

    task automatic push(input int due, input logic [3:0] tag,
                        input logic [31:0] data, input string req);
        exp_t e;
        e.due = due; e.tag = tag; e.data = data; e.req = req;
        expq.push_back(e);
    endtask

    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] tag, input int c);
        longint sa, sb, salo, sahi, sblo, sbhi;
        logic signed [15:0] h;
        logic [63:0] pu;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        h = a[15:0];  salo = h;
        h = a[31:16]; sahi = h;
        h = b[15:0];  sblo = h;
        h = b[31:16]; sbhi = h;
        case (op)
            3'd0: push(c + 2, tag, 32'(salo * sblo), "R2");
            3'd1: push(c + 2, tag, 32'(sa * sblo), "R2");
            3'd2: push(c + fin_of(op, b), tag, 32'(sa * sb), "R3");
            3'd3: begin pu = 64'(sa * sb); push(c + 5, tag, pu[63:32], "R4"); end
            3'd4: m_acc = m_acc + 40'(sa * sb);
            3'd5: m_acc = m_acc + 40'(salo * sblo + sahi * sbhi);
            3'd6: m_acc = {a[7:0], b};
            default: push(c + 2, tag, m_acc[31:0], rd_req);
        endcase
    endtask

    task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] tag, input bit keep, output int c);
        issue_valid = 1'b1;
        issue_op = op; issue_a = a; issue_b = b; issue_tag = tag;
        #1;
        while (!issue_ready) begin
            @(negedge clk);
            #1;
        end
        c = cyc;
        if (keep) model(op, a, b, tag, c);
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic pulse_flush(input int t);
        while (cyc < t) @(negedge clk);
        flush = 1'b1;
        #1;
        chk(issue_ready == 1'b0, "R7", "issue_ready during flush", 64'(issue_ready), 0);
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    // Result monitor: sampled mid-low-phase, away from both edges.
    always begin
        @(negedge clk);
        #5;
        if (!rst) begin
            while (expq.size() > 0 && expq[0].due < cyc) begin
                chk(1'b0, expq[0].req, "missing result, due cycle", 64'(cyc), 64'(expq[0].due));
                void'(expq.pop_front());
            end
            if (result_valid) begin
                rv_seen++;
                if (expq.size() == 0 || expq[0].due != cyc) begin
                    chk(1'b0, "R8", "unexpected result_valid, cycle", 64'(cyc),
                        expq.size() > 0 ? 64'(expq[0].due) : 64'(0));
                end else begin
                    chk(result_tag == expq[0].tag, "R10", "result_tag",
                        64'(result_tag), 64'(expq[0].tag));
                    chk(result_data == expq[0].data, expq[0].req, "result_data",
                        64'(result_data), 64'(expq[0].data));
                    void'(expq.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual cycle %0d expected end earlier", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c, c0, prev, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(issue_ready == 1'b1, "R1", "issue_ready after reset", 64'(issue_ready), 1);
        chk(result_valid == 1'b0, "R1", "result_valid after reset", 64'(result_valid), 0);
        @(negedge clk);

        // R2 sweep of both short multiplies, back to back; R7 one per cycle
        for (int op = 0; op < 2; op++) begin
            prev = -1;
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    send(3'(op), val(i), val(j), 4'(i + j), 1'b1, c);
                    if (prev >= 0)
                        chk(c == prev + 1, "R7", "short op accept cycle", 64'(c), 64'(prev + 1));
                    prev = c;
                end
            end
        end
        drain();

        // R3 low-word sweep with narrow and wide b; R4 high-word sweep
        for (int op = 2; op < 4; op++) begin
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    send(3'(op), val(i), val(j), 4'(i * 3 + j), 1'b1, c);
        end
        drain();

        // R7 admission spacing after long and medium operations
        send(3'd3, 32'd7, 32'd9, 4'd1, 1'b1, c0);
        send(3'd0, 32'd2, 32'd3, 4'd2, 1'b1, c);
        chk(c == c0 + 4, "R7", "issue after M5 op", 64'(c), 64'(c0 + 4));
        drain();
        send(3'd2, 32'd5, 32'h0001_A5C3, 4'd3, 1'b1, c0);
        send(3'd0, 32'd2, 32'd3, 4'd4, 1'b1, c);
        chk(c == c0 + 3, "R7", "issue after M4 op", 64'(c), 64'(c0 + 3));
        drain();
        send(3'd2, 32'd5, 32'hFFFF_FFF0, 4'd5, 1'b1, c0);
        send(3'd0, 32'd2, 32'd3, 4'd6, 1'b1, c);
        chk(c == c0 + 2, "R7", "issue after M3 op", 64'(c), 64'(c0 + 2));
        drain();

        // R5 accumulate sweeps, reading back after each row (R6 ordering)
        rd_req = "R5";
        send(3'd6, 32'd0, 32'd0, 4'd0, 1'b1, c);
        for (int op = 4; op < 6; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++)
                    send(3'(op), val(i), val(j), 4'd0, 1'b1, c);
                send(3'd7, 32'd0, 32'd0, 4'(i + 8), 1'b1, c);
            end
        end
        // R5 wrap at 2^40
        send(3'd6, 32'h0000_00FF, 32'hFFFF_FFFF, 4'd0, 1'b1, c);
        send(3'd4, 32'd1, 32'd2, 4'd0, 1'b1, c);
        send(3'd7, 32'd0, 32'd0, 4'd9, 1'b1, c);
        drain();

        // R6 load then read
        rd_req = "R6";
        send(3'd6, 32'h0000_0012, 32'hCAFE_F00D, 4'd0, 1'b1, c);
        send(3'd7, 32'd0, 32'd0, 4'd10, 1'b1, c);
        drain();

        // R8: flush in M2 cancels a 32x32 multiply
        n = rv_seen;
        send(3'd2, 32'd5, 32'h0001_0000, 4'd11, 1'b0, c);
        pulse_flush(c + 2);
        drain();
        chk(rv_seen == n, "R8", "results after flushed multiply", 64'(rv_seen), 64'(n));

        // R9: flush in M3 does not stop a high-word multiply
        n = rv_seen;
        send(3'd3, 32'h1234_5678, 32'h8765_4321, 4'd12, 1'b1, c);
        pulse_flush(c + 3);
        drain();
        chk(rv_seen == n + 1, "R9", "results after committed multiply", 64'(rv_seen), 64'(n + 1));

        // R8: accumulate flushed in M1 leaves accumulator untouched
        send(3'd6, 32'd0, 32'd100, 4'd0, 1'b1, c);
        drain();
        send(3'd4, 32'd3, 32'd4, 4'd0, 1'b0, c);
        pulse_flush(c + 1);
        drain();
        rd_req = "R8";
        send(3'd7, 32'd0, 32'd0, 4'd13, 1'b1, c);
        drain();

        // R9: accumulate flushed in M3 still lands
        send(3'd4, 32'd3, 32'd4, 4'd0, 1'b1, c);
        pulse_flush(c + 3);
        drain();
        rd_req = "R9";
        send(3'd7, 32'd0, 32'd0, 4'd14, 1'b1, c);
        drain();

        // R8: load flushed in its M2 cycle is dropped
        send(3'd6, 32'd0, 32'd999, 4'd0, 1'b0, c);
        pulse_flush(c + 2);
        drain();
        rd_req = "R8";
        send(3'd7, 32'd0, 32'd0, 4'd15, 1'b1, c);
        drain();

        chk(expq.size() == 0, "R10", "outstanding expected results", 64'(expq.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule